// File: doc/BRIEF.md
# Halt Beacon Timer Pair

This block turns a processor halt condition into a level on one output pin. A short-period master counter runs freely and raises an update trigger every time it wraps. A slave counter generates a PWM waveform over a long period. Each update trigger clears the slave counter back to zero. While triggers keep arriving, the slave never climbs out of its low region, so the pin stays low.

When the halt input freezes the master counter, the triggers stop. The slave keeps counting through its full period and the pin spends almost all of its time high. A brief low notch remains at the start of each period. Downstream logic, or a simple filter, can read the pin as "the core is halted".

Both counters have their own enable. The reload and compare values are inputs, so the default pairing and other ratios can be set at run time. A polarity input inverts the pin. Counter widths and the phase order of the PWM are parameters, and the parameter values are checked during elaboration.

Top module: `halt_beacon`

## Requirements
- R1: While the master is enabled and halt is low, the master count advances by one per clock. When it is at or above `mst_reload`, the next edge sets it to 0 and an update trigger is raised in that cycle. With `mst_reload` = 1 the master wraps every 2 clocks.
- R2: While halt is high, the master count holds its value and raises no trigger. The slave counter is not affected by halt.
- R3: While the slave is enabled and no trigger is present, the slave count advances by one per clock and wraps to 0 after reaching `slv_reload`. A reload of 65535 gives a period of 65536 clocks. A trigger that falls on the wrap cycle also yields 0.
- R4: With the default phase order and `pol_inv` = 0, the pin is 0 while the slave count is below `slv_cmp` and 1 while it is at or above `slv_cmp`.
- R5: An update trigger clears the slave count on the clock edge where it is present. A clear and an increment in the same cycle resolve to 0.
- R6: With `mst_reload` = 1, `slv_cmp` = 2 and the master running, the pin stays at its low level on every cycle.
- R7: With the master halted, `slv_reload` = 65535 and `slv_cmp` = 2, the pin is low on exactly 2 of every 65536 consecutive cycles and high on the other 65534.
- R8: `pol_inv` = 1 inverts the pin level in the same cycle.
- R9: A disabled master holds its count and produces no triggers, so the slave runs freely.
- R10: A disabled slave holds its count, and the pin sits at its inactive level, which equals `pol_inv`.
- R11: A synchronous reset (`rst` high at an edge) clears both counts to 0, so the pin shows its below-compare level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes the master counter while high |
| mst_en | input | 1 | Master counter enable |
| slv_en | input | 1 | Slave counter enable |
| mst_reload | input | MST_W | Master wrap value |
| slv_reload | input | SLV_W | Slave wrap value |
| slv_cmp | input | SLV_W | Slave compare threshold |
| pol_inv | input | 1 | Inverts the pin when high |
| beacon_pin | output | 1 | PWM halt indicator pin |

## Verification
Two events can land on the same slave edge: the master's update trigger and the slave's own increment or wrap. The collision of trigger and increment happens on every trigger and is judged by the pin never leaving its low level. The collision of trigger and wrap is provoked by giving both counters the same reload value. The bench then checks that exactly 60 of every 100 cycles are high. A behavioural model compares the pin on every clock, including the transients when halt, the enables and the reload values change mid-period.

// File: rtl/hb_pkg.sv
package hb_pkg;
   // phase order of the slave PWM waveform
   typedef enum logic {
      PWM_LOW_BELOW  = 1'b0,   // low below compare, high at or above
      PWM_HIGH_BELOW = 1'b1    // high below compare, low at or above
   } pwm_order_e;

   localparam int unsigned HB_MAX_W = 32;
endpackage

// File: rtl/hb_master_ctr.sv
module hb_master_ctr #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          halt,
   input  logic [CW-1:0] reload,
   output logic [CW-1:0] cnt,
   output logic          trig
);
   logic adv;
   logic at_top;

   assign adv    = en & ~halt;
   assign at_top = (cnt >= reload);
   assign trig   = adv & at_top;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= at_top ? '0 : cnt + CW'(1);
      end
   end
endmodule

// File: rtl/hb_slave_ctr.sv
module hb_slave_ctr #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          clr,
   input  logic [CW-1:0] reload,
   output logic [CW-1:0] cnt
);
   logic at_top;

   assign at_top = (cnt >= reload);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (en) begin
         if (clr || at_top) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/hb_pin_stage.sv
module hb_pin_stage #(
   parameter int unsigned      CW    = 16,
   parameter hb_pkg::pwm_order_e ORDER = hb_pkg::PWM_LOW_BELOW
) (
   input  logic          en,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] cmp,
   input  logic          pol_inv,
   output logic          pin
);
   logic below;
   logic act;

   assign below = (cnt < cmp);

   generate
      if (ORDER == hb_pkg::PWM_LOW_BELOW) begin : g_low_first
         assign act = ~below;
      end else begin : g_high_first
         assign act = below;
      end
   endgenerate

   assign pin = (en & act) ^ pol_inv;
endmodule

// File: rtl/halt_beacon.sv
module halt_beacon #(
   parameter int unsigned        MST_W = 16,
   parameter int unsigned        SLV_W = 16,
   parameter hb_pkg::pwm_order_e ORDER = hb_pkg::PWM_LOW_BELOW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             halt,
   input  logic             mst_en,
   input  logic             slv_en,
   input  logic [MST_W-1:0] mst_reload,
   input  logic [SLV_W-1:0] slv_reload,
   input  logic [SLV_W-1:0] slv_cmp,
   input  logic             pol_inv,
   output logic             beacon_pin
);
   localparam int unsigned MAX_W = hb_pkg::HB_MAX_W;

   generate
      if (MST_W < 1 || MST_W > MAX_W) begin : g_bad_mst_w
         $error("halt_beacon: MST_W out of range");
      end
      if (SLV_W < 2 || SLV_W > MAX_W) begin : g_bad_slv_w
         $error("halt_beacon: SLV_W out of range");
      end
   endgenerate

   logic [MST_W-1:0] mst_cnt;
   logic [SLV_W-1:0] slv_cnt;
   logic             upd_trig;

   hb_master_ctr #(.CW(MST_W)) u_master (
      .clk    (clk),
      .rst    (rst),
      .en     (mst_en),
      .halt   (halt),
      .reload (mst_reload),
      .cnt    (mst_cnt),
      .trig   (upd_trig)
   );

   hb_slave_ctr #(.CW(SLV_W)) u_slave (
      .clk    (clk),
      .rst    (rst),
      .en     (slv_en),
      .clr    (upd_trig),
      .reload (slv_reload),
      .cnt    (slv_cnt)
   );

   hb_pin_stage #(.CW(SLV_W), .ORDER(ORDER)) u_pin (
      .en      (slv_en),
      .cnt     (slv_cnt),
      .cmp     (slv_cmp),
      .pol_inv (pol_inv),
      .pin     (beacon_pin)
   );
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
   parameter int unsigned        MST_W = 16,
   parameter int unsigned        SLV_W = 16,
   parameter hb_pkg::pwm_order_e ORDER = hb_pkg::PWM_LOW_BELOW
) (
   input logic             clk,
   input logic             rst,
   input logic             halt,
   input logic             mst_en,
   input logic             slv_en,
   input logic [MST_W-1:0] mst_reload,
   input logic [SLV_W-1:0] slv_reload,
   input logic [SLV_W-1:0] slv_cmp,
   input logic             pol_inv,
   input logic             beacon_pin,
   input logic [MST_W-1:0] mst_cnt,
   input logic [SLV_W-1:0] slv_cnt,
   input logic             upd_trig
);
   localparam logic LOW_LVL = (ORDER == hb_pkg::PWM_LOW_BELOW) ? 1'b0 : 1'b1;

   assert_master_wrap_R1: assert property (@(posedge clk) disable iff (rst)
      (mst_en && !halt && mst_cnt >= mst_reload) |=> (mst_cnt == '0));

   assert_trig_then_zero_R1: assert property (@(posedge clk) disable iff (rst)
      upd_trig |=> (mst_cnt == '0));

   assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (rst)
      halt |=> $stable(mst_cnt));

   assert_halt_no_trig_R2: assert property (@(posedge clk) disable iff (rst)
      halt |-> !upd_trig);

   assert_slave_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (slv_en && !upd_trig && slv_cnt >= slv_reload) |=> (slv_cnt == '0));

   assert_below_level_R4: assert property (@(posedge clk) disable iff (rst)
      (slv_en && slv_cnt < slv_cmp) |-> (beacon_pin == (LOW_LVL ^ pol_inv)));

   assert_trig_clears_R5: assert property (@(posedge clk) disable iff (rst)
      (slv_en && upd_trig) |=> (slv_cnt == '0));

   assert_master_off_R9: assert property (@(posedge clk) disable iff (rst)
      !mst_en |-> !upd_trig);

   assert_slave_off_pin_R10: assert property (@(posedge clk) disable iff (rst)
      !slv_en |-> (beacon_pin == pol_inv));

   assert_slave_off_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !slv_en |=> $stable(slv_cnt));

   assert_reset_clear_R11: assert property (@(posedge clk)
      rst |=> (mst_cnt == '0 && slv_cnt == '0));
endmodule

bind halt_beacon hb_checker #(.MST_W(MST_W), .SLV_W(SLV_W), .ORDER(ORDER)) u_hb_chk (
   .clk        (clk),
   .rst        (rst),
   .halt       (halt),
   .mst_en     (mst_en),
   .slv_en     (slv_en),
   .mst_reload (mst_reload),
   .slv_reload (slv_reload),
   .slv_cmp    (slv_cmp),
   .pol_inv    (pol_inv),
   .beacon_pin (beacon_pin),
   .mst_cnt    (mst_cnt),
   .slv_cnt    (slv_cnt),
   .upd_trig   (upd_trig)
);

// File: tb/test_halt_beacon.sv
module test_halt_beacon;
   localparam int CLK_PERIOD   = 10;
   localparam int WATCHDOG_CYC = 150000;

   logic        clk = 1'b0;
   logic        rst;
   logic        halt;
   logic        mst_en;
   logic        slv_en;
   logic [15:0] mst_reload;
   logic [15:0] slv_reload;
   logic [15:0] slv_cmp;
   logic        pol_inv;
   logic        beacon_pin;

   always #(CLK_PERIOD/2) clk = ~clk;

   halt_beacon i_halt_beacon (
      .clk        (clk),
      .rst        (rst),
      .halt       (halt),
      .mst_en     (mst_en),
      .slv_en     (slv_en),
      .mst_reload (mst_reload),
      .slv_reload (slv_reload),
      .slv_cmp    (slv_cmp),
      .pol_inv    (pol_inv),
      .beacon_pin (beacon_pin)
   );

   int    total = 0;
   int    bad   = 0;
   bit    done  = 0;
   bit    armed = 0;
   string phase = "R11";

   // behavioural reference state
   int mc = 0;
   int sc = 0;

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model_pin();
      int lvl;
      if (!slv_en) return int'(pol_inv);
      lvl = (sc >= int'(slv_cmp)) ? 1 : 0;
      return lvl ^ int'(pol_inv);
   endfunction

   always @(posedge clk) begin
      bit t;
      if (rst) begin
         mc = 0;
         sc = 0;
      end else begin
         t = mst_en && !halt && (mc >= int'(mst_reload));
         if (mst_en && !halt) mc = (mc >= int'(mst_reload)) ? 0 : mc + 1;
         if (slv_en) begin
            if (t) sc = 0;
            else   sc = (sc >= int'(slv_reload)) ? 0 : sc + 1;
         end
      end
      armed = 1;
   end

   always @(negedge clk) begin
      #2;
      if (armed && !done) check(int'(beacon_pin) == model_pin(), phase, int'(beacon_pin), model_pin());
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_high(int n, output int h);
      h = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #3;
         h += int'(beacon_pin);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      int h;
      rst = 1'b1; halt = 1'b0; mst_en = 1'b1; slv_en = 1'b1;
      mst_reload = 16'd1; slv_reload = 16'd65535; slv_cmp = 16'd2; pol_inv = 1'b0;
      cyc(3);
      #3;
      phase = "R11";
      check(beacon_pin == 1'b0, "R11 reset level", int'(beacon_pin), 0);
      cyc(1);
      rst = 1'b0;

      // R6: master running keeps the pin low
      phase = "R6";
      count_high(200, h);
      check(h == 0, "R6 running pin low", h, 0);

      // R7 / R2: halted master, exactly 2 low cycles per 65536
      @(negedge clk);
      phase = "R7";
      halt = 1'b1;
      count_high(65536, h);
      check(h == 65534, "R7 halted high count", h, 65534);

      // R8: release halt with inverted polarity, pin settles high
      @(negedge clk);
      phase = "R8";
      halt = 1'b0;
      pol_inv = 1'b1;
      cyc(6);
      count_high(50, h);
      check(h == 50, "R8 inverted running level", h, 50);
      @(negedge clk);
      pol_inv = 1'b0;

      // R4: master period 7, slave threshold 4 -> 3 high of 7
      phase = "R4";
      mst_reload = 16'd6; slv_reload = 16'd9; slv_cmp = 16'd4;
      cyc(20);
      count_high(70, h);
      check(h == 30, "R4 compare duty", h, 30);

      // R5: master period 3, slave cleared before threshold
      @(negedge clk);
      phase = "R5";
      mst_reload = 16'd2;
      cyc(10);
      count_high(100, h);
      check(h == 0, "R5 clear beats increment", h, 0);

      // R3: trigger coincides with slave wrap (equal reloads)
      @(negedge clk);
      phase = "R3";
      mst_reload = 16'd9;
      cyc(20);
      count_high(100, h);
      check(h == 60, "R3 trigger on wrap", h, 60);

      // R1: short master reload wraps every 2 clocks
      @(negedge clk);
      phase = "R1";
      mst_reload = 16'd1; slv_cmp = 16'd2;
      cyc(10);
      count_high(60, h);
      check(h == 0, "R1 two-clock master wrap", h, 0);

      // R9: master disabled, slave runs freely (6 high of 10)
      @(negedge clk);
      phase = "R9";
      mst_en = 1'b0; slv_cmp = 16'd4;
      cyc(5);
      count_high(100, h);
      check(h == 60, "R9 master disabled", h, 60);

      // R10: slave disabled, pin at inactive level
      @(negedge clk);
      phase = "R10";
      slv_en = 1'b0; pol_inv = 1'b1;
      count_high(20, h);
      check(h == 20, "R10 disabled inverted", h, 20);
      @(negedge clk);
      pol_inv = 1'b0;
      count_high(20, h);
      check(h == 0, "R10 disabled plain", h, 0);
      @(negedge clk);
      slv_en = 1'b1; mst_en = 1'b1;
      cyc(30);

      // R2: halt with master enabled lets slave run freely again
      @(negedge clk);
      phase = "R2";
      halt = 1'b1;
      cyc(5);
      count_high(100, h);
      check(h == 60, "R2 halt frees slave", h, 60);

      // R11: mid-run reset
      @(negedge clk);
      phase = "R11";
      rst = 1'b1;
      cyc(1);
      #3;
      check(beacon_pin == 1'b0, "R11 mid-run reset level", int'(beacon_pin), 0);
      @(negedge clk);
      rst = 1'b0;
      cyc(20);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
         summary();
         $finish;
      end
   end
endmodule